// File: doc/BRIEF.md
# Interlocked Bus Master Transfer Engine

This block is the master half of an asynchronous, fully interlocked parallel bus. A local requester presents one of four operations: plain read, read that opens a read-modify-write pause, full-word write, or single-byte write. It also presents an address and write data. The engine then waits for bus mastership through a simple grant input and drives address, function code and data. After a programmable settling delay it raises its master strobe. It lowers the strobe only after the slave acknowledges, and it waits for the acknowledge to fall before it reports completion.

Reads return the full word, the byte lane chosen by the request's low address bit, and a parity error flag decoded from the slave's two-bit status. A pause read keeps the bus held without a gap until the write to the same word finishes, and any other request in that window is refused. A slave that never answers is cut off by a timeout counter and reported as a bus error.

Top module: `ilbus_master`

## Requirements
- R1: The master strobe rises exactly SKEW cycles after the engine starts driving address, function and data (the first cycle bus_hold is high on a non-locked transfer). It stays high until the cycle after bus_sack is seen high, so a slave that answers d cycles after seeing the strobe sees it for d+1 cycles. Address and function stay stable while the strobe is high.
- R2: The strobe never rises while bus_sack is still high from a previous transfer. The response pulse is issued only once bus_sack has fallen again.
- R3: Operations are encoded as req_op 0 = read, 1 = pause read, 2 = word write, 3 = byte write, and bus_func carries the same code. On both reads rsp_data is the full word on bus_din. rsp_byte is bus_din[7:0] when request address bit 0 is 0 and bus_din[15:8] when it is 1. bus_addr bit 0 is driven 0 on reads and word writes.
- R4: On a byte write the byte req_wdata[7:0] appears on bus_dout[7:0] when address bit 0 is 0 and on bus_dout[15:8] when it is 1, with the other lane zero and bus_addr bit 0 equal to the request's. A word write drives req_wdata unchanged. bus_doe is high during both.
- R5: After a pause read completes without error, bus_hold stays high on every cycle, with no grant needed, until a write to the same word completes. bus_hold is low when that write's response appears.
- R6: While a pause is open, a read of any kind or a write to another word is answered with rsp_rej and starts no bus cycle. bus_hold stays high and the pause stays open.
- R7: rsp_perr is set on a read only when bus_perr_code is 2'b01 at the acknowledge. Codes 2'b00, 2'b10 and 2'b11 do not flag, and writes never flag.
- R8: If bus_sack does not arrive within TMO strobe cycles, the strobe falls and the response carries rsp_berr. A timed-out pause read opens no pause, and a timed-out locked write closes it.
- R9: Without an open pause the engine raises bus_hold and starts a cycle only after bus_grant is high. req_ready is high only while the engine is idle.
- R10: After reset the strobe, bus_hold and rsp_valid are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken on this cycle |
| req_op | input | 2 | Operation code |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data (byte in [7:0] for byte writes) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DW | Read word |
| rsp_byte | output | 8 | Read byte lane selected by address bit 0 |
| rsp_perr | output | 1 | Slave parity error on read |
| rsp_berr | output | 1 | Acknowledge timeout |
| rsp_rej | output | 1 | Request refused during an open pause |
| bus_grant | input | 1 | Mastership granted |
| bus_hold | output | 1 | Bus busy, held by this master |
| bus_addr | output | AW | Bus address |
| bus_func | output | 2 | Bus function code |
| bus_dout | output | DW | Bus write data |
| bus_doe | output | 1 | Write data valid on bus_dout |
| bus_mstrobe | output | 1 | Master strobe |
| bus_sack | input | 1 | Slave acknowledge |
| bus_din | input | DW | Bus read data |
| bus_perr_code | input | 2 | Slave parity status |

## Verification
A bench slave model sweeps every operation against both values of address bit 0, all four parity codes and three acknowledge delays. Between them, these cases separate the lane choice on reads and writes, the code 01 parity flag from the reserved codes, and strobe lengths that follow the slave from ones that are fixed. Each pause read is followed by a read to the same word, a write to another word and then the proper write with the grant withdrawn, which tells refusal apart from a held bus. Silent slaves, an acknowledge left high before a request, and a withheld grant exercise the timeout, the interlock on the strobe rise and the gating on mastership.

// File: rtl/ilbus_pkg.sv
package ilbus_pkg;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_RDP = 2'd1,
        OP_WR  = 2'd2,
        OP_WRB = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARB,
        S_SETUP,
        S_STROBE,
        S_RELEASE
    } st_e;

    function automatic logic is_write(op_e op);
        return op[1];
    endfunction

    localparam logic [1:0] PCODE_ERR = 2'b01;

endpackage

// File: rtl/ilbus_lane.sv
module ilbus_lane #(
    parameter int DW = 16,
    parameter int LB = 1
) (
    input  logic [LB-1:0] sel,
    input  logic [7:0]    wbyte,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] lanes,
    output logic [7:0]    pick
);
    localparam int NB = DW / 8;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lanes[8*g +: 8] = (sel == LB'(g)) ? wbyte : 8'h00;
    end

    always_comb begin
        pick = 8'h00;
        for (int i = 0; i < NB; i++) begin
            if (sel == LB'(i)) pick = word[8*i +: 8];
        end
    end

endmodule

// File: rtl/ilbus_guard.sv
module ilbus_guard #(
    parameter int WAW = 11
) (
    input  logic             lock,
    input  logic [WAW-1:0]   lock_wa,
    input  logic [WAW-1:0]   req_wa,
    input  ilbus_pkg::op_e   op,
    output logic             pass
);
    assign pass = !lock || (ilbus_pkg::is_write(op) && (req_wa == lock_wa));
endmodule

// File: rtl/ilbus_timer.sv
module ilbus_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)               cnt_d = '0;
        else if (cnt_q != '1)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ilbus_master.sv
module ilbus_master
    import ilbus_pkg::*;
#(
    parameter int AW   = 18,
    parameter int DW   = 16,
    parameter int SKEW = 2,
    parameter int TMO  = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic [7:0]    rsp_byte,
    output logic          rsp_perr,
    output logic          rsp_berr,
    output logic          rsp_rej,
    input  logic          bus_grant,
    output logic          bus_hold,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_func,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    output logic          bus_mstrobe,
    input  logic          bus_sack,
    input  logic [DW-1:0] bus_din,
    input  logic [1:0]    bus_perr_code
);
    localparam int NB  = DW / 8;
    localparam int LB  = $clog2(NB);
    localparam int WAW = AW - LB;
    localparam int CW  = $clog2(TMO + SKEW + 2);
    localparam logic [CW-1:0] SKW_LIM = CW'((SKEW > 0) ? SKEW - 1 : 0);
    localparam logic [CW-1:0] TMO_LIM = CW'((TMO > 0) ? TMO - 1 : 0);

    typedef struct packed {
        st_e            st;
        op_e            op;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic [1:0]     pcode;
        logic           tmo;
        logic           hold;
        logic           strobe;
        logic           lock;
        logic [WAW-1:0] lock_wa;
        logic           rsp_v;
        logic           rsp_rej;
        logic           rsp_berr;
        logic           rsp_perr;
    } regs_t;

    regs_t r_d, r_q;
    logic [CW-1:0] cnt;
    logic          pass;
    logic [DW-1:0] lanes;
    op_e           req_op_e;

    assign req_op_e = op_e'(req_op);

    ilbus_guard #(.WAW(WAW)) u_guard (
        .lock    (r_q.lock),
        .lock_wa (r_q.lock_wa),
        .req_wa  (req_addr[AW-1:LB]),
        .op      (req_op_e),
        .pass    (pass)
    );

    ilbus_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (r_d.st != r_q.st),
        .cnt   (cnt)
    );

    ilbus_lane #(.DW(DW), .LB(LB)) u_lane (
        .sel   (r_q.addr[LB-1:0]),
        .wbyte (r_q.wdata[7:0]),
        .word  (r_q.rdata),
        .lanes (lanes),
        .pick  (rsp_byte)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rsp_v    = 1'b0;
        r_d.rsp_rej  = 1'b0;
        r_d.rsp_berr = 1'b0;
        r_d.rsp_perr = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    if (!pass) begin
                        r_d.rsp_v   = 1'b1;
                        r_d.rsp_rej = 1'b1;
                    end else begin
                        r_d.op    = req_op_e;
                        r_d.addr  = req_addr;
                        r_d.wdata = req_wdata;
                        r_d.tmo   = 1'b0;
                        r_d.st    = r_q.lock ? S_SETUP : S_ARB;
                    end
                end
            end
            S_ARB: begin
                if (bus_grant) begin
                    r_d.hold = 1'b1;
                    r_d.st   = S_SETUP;
                end
            end
            S_SETUP: begin
                if (cnt >= SKW_LIM && !bus_sack) begin
                    r_d.strobe = 1'b1;
                    r_d.st     = S_STROBE;
                end
            end
            S_STROBE: begin
                if (bus_sack) begin
                    r_d.strobe = 1'b0;
                    r_d.rdata  = bus_din;
                    r_d.pcode  = bus_perr_code;
                    r_d.st     = S_RELEASE;
                end else if (cnt >= TMO_LIM) begin
                    r_d.strobe = 1'b0;
                    r_d.tmo    = 1'b1;
                    r_d.st     = S_RELEASE;
                end
            end
            S_RELEASE: begin
                if (!bus_sack) begin
                    r_d.st       = S_IDLE;
                    r_d.rsp_v    = 1'b1;
                    r_d.rsp_berr = r_q.tmo;
                    r_d.rsp_perr = !r_q.tmo && !is_write(r_q.op) &&
                                   (r_q.pcode == PCODE_ERR);
                    if (is_write(r_q.op)) begin
                        r_d.lock = 1'b0;
                    end else if (r_q.op == OP_RDP && !r_q.tmo) begin
                        r_d.lock    = 1'b1;
                        r_d.lock_wa = r_q.addr[AW-1:LB];
                    end
                    r_d.hold = r_d.lock;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == S_IDLE);
    assign rsp_valid   = r_q.rsp_v;
    assign rsp_data    = r_q.rdata;
    assign rsp_perr    = r_q.rsp_perr;
    assign rsp_berr    = r_q.rsp_berr;
    assign rsp_rej     = r_q.rsp_rej;
    assign bus_hold    = r_q.hold;
    assign bus_mstrobe = r_q.strobe;
    assign bus_func    = r_q.op;
    assign bus_addr    = (r_q.op == OP_WRB) ? r_q.addr
                                            : {r_q.addr[AW-1:LB], {LB{1'b0}}};
    assign bus_dout    = (r_q.op == OP_WRB) ? lanes : r_q.wdata;
    assign bus_doe     = is_write(r_q.op) &&
                         (r_q.st == S_SETUP || r_q.st == S_STROBE);

    // R1: the strobe drops only after an acknowledge or a timeout.
    a_r1_strobe_ends_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_mstrobe) |-> ($past(bus_sack) || $past(cnt) >= TMO_LIM));

    // R1: address and function stay still while the strobe is up.
    a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mstrobe && $past(bus_mstrobe)) |-> ($stable(bus_addr) && $stable(bus_func)));

    // R2: no strobe rise against a lingering acknowledge.
    a_r2_rise_after_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_mstrobe) |-> !$past(bus_sack));

    // R3: reads and word writes keep the byte-select address bits at zero.
    a_r3_read_a0_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mstrobe && bus_func != OP_WRB) |-> (bus_addr[LB-1:0] == '0));

    // R5: the bus is let go only at the end of a transfer.
    a_r5_hold_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_hold) |-> $past(rsp_valid == 1'b0) && rsp_valid);

    // R6: a refusal starts no bus cycle and leaves the bus held.
    a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rej |-> (!bus_mstrobe && bus_hold));

    // R8: a bus error response carries no other flag.
    a_r8_berr_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_berr) |-> (!rsp_perr && !rsp_rej));

    // R9: the strobe is only up while the bus is held.
    a_r9_strobe_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mstrobe |-> bus_hold);

endmodule

// File: tb/ilbus_master_tb.sv
module ilbus_master_tb;
    localparam int CLK_NS = 10;
    localparam int AW     = 12;
    localparam int DW     = 16;
    localparam int SKEW   = 2;
    localparam int TMO    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [7:0]    rsp_byte;
    logic          rsp_perr, rsp_berr, rsp_rej;
    logic          bus_grant = 1'b1;
    logic          bus_hold;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_func;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;
    logic          bus_mstrobe;
    logic          bus_sack = 1'b0;
    logic [DW-1:0] bus_din = '0;
    logic [1:0]    bus_perr_code = 2'b00;

    ilbus_master #(.AW(AW), .DW(DW), .SKEW(SKEW), .TMO(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_byte(rsp_byte),
        .rsp_perr(rsp_perr), .rsp_berr(rsp_berr), .rsp_rej(rsp_rej),
        .bus_grant(bus_grant), .bus_hold(bus_hold), .bus_addr(bus_addr),
        .bus_func(bus_func), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_mstrobe(bus_mstrobe), .bus_sack(bus_sack), .bus_din(bus_din),
        .bus_perr_code(bus_perr_code)
    );

    initial forever #(CLK_NS/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // slave model controls and observations
    int            sl_delay = 0;
    bit            sl_mute = 0, sl_force = 0;
    logic [DW-1:0] sl_rdata = '0;
    logic [1:0]    sl_code = 2'b00;
    logic [AW-1:0] cap_addr;
    logic [1:0]    cap_func;
    logic [DW-1:0] cap_dout;
    logic          cap_doe;
    int  dcnt = 0, n_rise = 0, rise_bad = 0, cur_len = 0, last_len = 0;
    int  pre_cnt = 0, last_pre = 0, hold_bad = 0;
    bit  prev_stb = 0, tb_lock = 0;

    // captured response
    logic [DW-1:0] g_data;
    logic [7:0]    g_byte;
    logic          g_perr, g_berr, g_rej, g_hold, g_sack;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (bus_mstrobe && !prev_stb) begin
                n_rise++;
                if (bus_sack) rise_bad++;
                last_pre = pre_cnt;
                pre_cnt  = 0;
                cur_len  = 0;
            end
            if (bus_mstrobe) cur_len++;
            else if (prev_stb) last_len = cur_len;
            if (!bus_hold) pre_cnt = 0;
            else if (!bus_mstrobe) pre_cnt++;
            if (tb_lock && !bus_hold && !rsp_valid) hold_bad++;
            prev_stb = bus_mstrobe;
            if (sl_force) begin
                bus_sack = 1'b1;
                dcnt = 0;
            end else if (sl_mute) begin
                bus_sack = 1'b0;
            end else if (bus_mstrobe && !bus_sack) begin
                if (dcnt >= sl_delay) begin
                    bus_sack      = 1'b1;
                    bus_din       = sl_rdata;
                    bus_perr_code = sl_code;
                    cap_addr = bus_addr;
                    cap_func = bus_func;
                    cap_dout = bus_dout;
                    cap_doe  = bus_doe;
                end else begin
                    dcnt++;
                end
            end else if (!bus_mstrobe && bus_sack) begin
                bus_sack = 1'b0;
                dcnt = 0;
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(input string tag);
        bit got = 0;
        for (int i = 0; i < 200 && !got; i++) begin
            if (rsp_valid) begin
                got = 1;
                g_data = rsp_data; g_byte = rsp_byte; g_perr = rsp_perr;
                g_berr = rsp_berr; g_rej = rsp_rej; g_hold = bus_hold; g_sack = bus_sack;
            end else begin
                @(negedge clk);
            end
        end
        chk({tag, " response arrives"}, 32'(got), 32'd1);
    endtask

    task automatic xfer(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w);
        issue(op, a, w);
        wait_rsp("R2");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int rise0;
        int idx = 0;
        logic [AW-1:0] a;
        logic [DW-1:0] w, exp_dout;
        logic [7:0]    exp_byte;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 strobe", 32'(bus_mstrobe), 0);
        chk("R10 hold", 32'(bus_hold), 0);
        chk("R10 ready", 32'(req_ready), 1);
        chk("R10 rsp_valid", 32'(rsp_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 grant gating
        bus_grant = 1'b0;
        rise0 = n_rise;
        sl_rdata = 16'h1234;
        issue(2'd0, 12'h100, '0);
        repeat (6) @(negedge clk);
        chk("R9 no hold without grant", 32'(bus_hold), 0);
        chk("R9 no strobe without grant", 32'(n_rise - rise0), 0);
        chk("R9 ready low while busy", 32'(req_ready), 0);
        bus_grant = 1'b1;
        wait_rsp("R9");
        chk("R9 read after grant", 32'(g_data), 32'h1234);
        chk("R1 deskew after grant", 32'(last_pre), SKEW);

        // Sweep: plain read, word write, byte write
        foreach (sl_delay_set[k]) ;
        for (int op = 0; op < 4; op++) begin
            if (op == 1) continue;
            for (int b = 0; b < 2; b++)
                for (int code = 0; code < 4; code++)
                    for (int dl = 0; dl < 3; dl++) begin
                        idx++;
                        sl_delay = (dl == 2) ? 3 : dl;
                        sl_code  = 2'(code);
                        sl_rdata = 16'hA5C3 ^ 16'(idx * 16'h0137);
                        a = 12'(12'h200 + (idx << 1) + b);
                        w = 16'h5A00 ^ 16'(idx * 16'h0711);
                        xfer(2'(op), a, w);
                        chk("R1 deskew", 32'(last_pre), SKEW);
                        chk("R1 strobe length", 32'(last_len), 32'(sl_delay + 1));
                        chk("R2 sack low at response", 32'(g_sack), 0);
                        chk("R3 function code", 32'(cap_func), 32'(op));
                        chk("R3 word address", 32'(cap_addr[AW-1:1]), 32'(a[AW-1:1]));
                        chk("R7 parity flag", 32'(g_perr), 32'(op == 0 && code == 1));
                        chk("R5 hold released", 32'(g_hold), 0);
                        if (op == 0) begin
                            exp_byte = b ? sl_rdata[15:8] : sl_rdata[7:0];
                            chk("R3 read word", 32'(g_data), 32'(sl_rdata));
                            chk("R3 read byte lane", 32'(g_byte), 32'(exp_byte));
                            chk("R3 a0 low on read", 32'(cap_addr[0]), 0);
                        end else begin
                            exp_dout = (op == 2) ? w : (b ? {w[7:0], 8'h00} : {8'h00, w[7:0]});
                            chk("R4 write data lanes", 32'(cap_dout), 32'(exp_dout));
                            chk("R4 data enable", 32'(cap_doe), 1);
                            chk("R4 a0 on bus", 32'(cap_addr[0]), 32'(op == 3 ? b : 0));
                        end
                    end
        end

        // Sweep: pause read, refusals, then the paired write
        for (int b = 0; b < 2; b++)
            for (int code = 0; code < 4; code++)
                for (int dl = 0; dl < 3; dl++) begin
                    idx++;
                    sl_delay = (dl == 2) ? 3 : dl;
                    sl_code  = 2'(code);
                    sl_rdata = 16'h3C96 ^ 16'(idx * 16'h0259);
                    a = 12'(12'h600 + (idx << 1) + b);
                    w = 16'hC300 ^ 16'(idx * 16'h0103);
                    xfer(2'd1, a, w);
                    exp_byte = b ? sl_rdata[15:8] : sl_rdata[7:0];
                    chk("R3 pause read word", 32'(g_data), 32'(sl_rdata));
                    chk("R3 pause read byte", 32'(g_byte), 32'(exp_byte));
                    chk("R3 pause function", 32'(cap_func), 1);
                    chk("R7 pause parity", 32'(g_perr), 32'(code == 1));
                    chk("R5 hold kept after pause", 32'(g_hold), 1);
                    tb_lock = 1;
                    bus_grant = 1'b0;
                    rise0 = n_rise;
                    xfer(2'd0, a, '0);
                    chk("R6 read refused", 32'(g_rej), 1);
                    xfer(2'd2, a ^ 12'h002, w);
                    chk("R6 other word refused", 32'(g_rej), 1);
                    chk("R6 no bus cycle", 32'(n_rise - rise0), 0);
                    chk("R6 hold during refusal", 32'(g_hold), 1);
                    xfer((code[0] ? 2'd3 : 2'd2), a, w);
                    chk("R5 paired write accepted", 32'(g_rej), 0);
                    chk("R5 paired write on bus", 32'(n_rise - rise0), 1);
                    chk("R5 hold released after write", 32'(g_hold), 0);
                    tb_lock = 0;
                    bus_grant = 1'b1;
                    chk("R5 hold continuous", 32'(hold_bad), 0);
                end

        // R8 timeout on a plain read
        sl_delay = 0;
        sl_mute = 1;
        xfer(2'd0, 12'h040, '0);
        chk("R8 berr on read", 32'(g_berr), 1);
        chk("R8 strobe cut at limit", 32'(last_len), TMO);
        chk("R8 no parity on berr", 32'(g_perr), 0);
        // R8 timed-out pause read leaves no pause
        xfer(2'd1, 12'h044, '0);
        chk("R8 berr on pause read", 32'(g_berr), 1);
        chk("R8 no hold after failed pause", 32'(g_hold), 0);
        sl_mute = 0;
        xfer(2'd0, 12'h048, '0);
        chk("R8 next read not refused", 32'(g_rej), 0);
        // R8 timed-out locked write closes the pause
        xfer(2'd1, 12'h04C, '0);
        chk("R8 pause opened", 32'(g_hold), 1);
        sl_mute = 1;
        xfer(2'd2, 12'h04C, 16'h7777);
        chk("R8 berr on locked write", 32'(g_berr), 1);
        chk("R8 hold dropped", 32'(g_hold), 0);
        sl_mute = 0;
        xfer(2'd0, 12'h050, '0);
        chk("R8 pause closed", 32'(g_rej), 0);

        // R2 lingering acknowledge blocks the strobe
        sl_force = 1;
        repeat (2) @(negedge clk);
        rise0 = n_rise;
        sl_rdata = 16'hBEEF;
        issue(2'd0, 12'h080, '0);
        repeat (8) @(negedge clk);
        chk("R2 no strobe while ack high", 32'(n_rise - rise0), 0);
        sl_force = 0;
        wait_rsp("R2");
        chk("R2 read after ack fell", 32'(g_data), 32'hBEEF);
        chk("R2 no rise against ack", 32'(rise_bad), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    int sl_delay_set[1];

endmodule